// File: doc/BRIEF.md
# Coprocessor Instruction Capture and Dispatch

This block sits next to an integer pipeline and listens to the shared 32-bit address and data buses. It captures every fetched instruction word, whether it is meant for the coprocessor or not. It joins each word to the address it was fetched from and keeps a short history of these pairs. The host drives a fetch address in one cycle and raises an instruction-valid strobe in the next. The instruction word then shows up on the data bus one cycle after that strobe. The block therefore holds each address for two cycles before it can form the pair.

The integer unit launches a stored pair by pulsing one of two dispatch strobes during its decode stage. The block acts on the strobe at the clock edge that opens the execute stage. For the following cycle it presents the chosen instruction and address together with a one-cycle issue pulse, which keeps the two pipelines in step. A pipeline hold input freezes the capture history. Decoding the opcode, arithmetic and memory control all sit outside this block.

Top module: `cpd_top`

## Requirements
- R1: The address on `fetch_addr` in cycle T is paired with the word on `fetch_data` in cycle T+2, provided `insn_valid` is high in cycle T+1. Addresses from other cycles and data words from cycles with no strobe one cycle earlier are never stored.
- R2: Every completed fetch is stored, whatever its contents. Back-to-back fetches, with `insn_valid` high on consecutive cycles, each add one pair, and the older pair moves down one slot.
- R3: A pulse on `disp_newest` in cycle D issues the most recently captured pair as it stands in cycle D.
- R4: A pulse on `disp_older` alone in cycle D issues the pair captured one fetch before the most recent one.
- R5: When both dispatch strobes are high in the same cycle, `disp_newest` takes priority.
- R6: `issue_vld` is high in cycle D+1 exactly when a strobe in cycle D selects a valid pair. `issue_insn` and `issue_addr` carry that pair in that cycle. Each strobe cycle gives at most one issue cycle.
- R7: While `hold` is high, the stored history does not change. A pair that completes in a cycle with `hold` high is dropped.
- R8: Reset clears every stored pair and its valid flag. A strobe that selects an empty slot produces no issue pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_addr | input | 32 | Snooped address bus |
| fetch_data | input | 32 | Snooped data bus |
| insn_valid | input | 1 | Host strobe, one cycle after a fetch address |
| disp_newest | input | 1 | Dispatch strobe for the newest pair |
| disp_older | input | 1 | Dispatch strobe for the previous pair |
| hold | input | 1 | Pipeline hold, freezes the history |
| issue_vld | output | 1 | One-cycle issue pulse |
| issue_insn | output | 32 | Issued instruction word |
| issue_addr | output | 32 | Issued fetch address |

## Verification
On every cycle, the assertions check several things. They check that a pending pair always traces back to a strobe, and that the history shifts in order and stays still under hold. They check that the valid flags stay contiguous, that an issue pulse always follows a strobe, and that the selected slot and priority match what was issued. The bench scenarios cover the end-to-end behaviour. They show that the right address is joined to the right word across the two-cycle skew, and that junk on the buses between fetches is never stored. They also show that a pair dropped under hold never comes back, and that strobes issued in the middle of a fetch burst see the history from before that cycle's capture.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic [WORD_W-1:0] insn;
    logic [WORD_W-1:0] addr;
  } pair_t;

  // Returns {fire_request, slot_index}: the newest strobe selects slot 0
  // and wins over the older strobe, which selects slot 1.
  function automatic logic [1:0] pick_slot(input logic newest, input logic older);
    logic [1:0] r;
    if (newest)     r = 2'b10;
    else if (older) r = 2'b11;
    else            r = 2'b00;
    return r;
  endfunction
endpackage

// File: rtl/cpd_align.sv
module cpd_align
  import cpd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] fetch_addr,
  input  logic              insn_valid,
  output logic              pend_vld,
  output logic [WORD_W-1:0] pend_addr
);
  logic [WORD_W-1:0] addr_d1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_d1   <= '0;
      pend_addr <= '0;
      pend_vld  <= 1'b0;
    end else begin
      addr_d1   <= fetch_addr;
      pend_addr <= addr_d1;
      pend_vld  <= insn_valid;
    end
  end

  // R1: a pending pair is only ever opened by the valid strobe
  assert_pend_from_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pend_vld |-> $past(insn_valid));
endmodule

// File: rtl/cpd_history.sv
module cpd_history
  import cpd_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              hold,
  input  pair_t             new_pair,
  output pair_t [DEPTH-1:0] slots,
  output logic  [DEPTH-1:0] slot_vld
);
  logic shift_en;
  assign shift_en = push && !hold;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          slots[0]    <= '0;
          slot_vld[0] <= 1'b0;
        end else if (shift_en) begin
          slots[0]    <= new_pair;
          slot_vld[0] <= 1'b1;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          slots[i]    <= '0;
          slot_vld[i] <= 1'b0;
        end else if (shift_en) begin
          slots[i]    <= slots[i-1];
          slot_vld[i] <= slot_vld[i-1];
        end
      end
    end
  end

  // R7: hold freezes the whole history
  assert_hold_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(slots) && $stable(slot_vld)));
  // R2: an accepted push moves the newest pair down one slot
  assert_shift_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !hold) |=> (slots[1] == $past(slots[0])));
  // R8: valid flags fill from the head, never with a gap
  assert_vld_contiguous_R8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_vld[1] |-> slot_vld[0]);
endmodule

// File: rtl/cpd_issue.sv
module cpd_issue
  import cpd_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_newest,
  input  logic              disp_older,
  input  pair_t [DEPTH-1:0] slots,
  input  logic  [DEPTH-1:0] slot_vld,
  output logic              issue_vld,
  output pair_t             issue_pair
);
  logic [1:0] pick;
  logic       sel_idx;
  logic       sel_fire;

  assign pick     = pick_slot(disp_newest, disp_older);
  assign sel_idx  = pick[0];
  assign sel_fire = pick[1] && slot_vld[sel_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue_vld  <= 1'b0;
      issue_pair <= '0;
    end else begin
      issue_vld <= sel_fire;
      if (sel_fire) issue_pair <= slots[sel_idx];
    end
  end

  // R6: an issue pulse always follows a strobe by one cycle
  assert_issue_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |-> $past(disp_newest || disp_older));
  // R5: with both strobes high the newest pair is issued
  assert_newest_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_newest && disp_older && slot_vld[0]) |=> (issue_vld && issue_pair == $past(slots[0])));
  // R4: the older strobe alone issues the second slot
  assert_older_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_older && !disp_newest && slot_vld[1]) |=> (issue_vld && issue_pair == $past(slots[1])));
  // R8: an empty history never issues
  assert_empty_no_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_vld[0] |=> !issue_vld);
endmodule

// File: rtl/cpd_top.sv
module cpd_top
  import cpd_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] fetch_addr,
  input  logic [WORD_W-1:0] fetch_data,
  input  logic              insn_valid,
  input  logic              disp_newest,
  input  logic              disp_older,
  input  logic              hold,
  output logic              issue_vld,
  output logic [WORD_W-1:0] issue_insn,
  output logic [WORD_W-1:0] issue_addr
);
  logic              pend_vld;
  logic [WORD_W-1:0] pend_addr;
  pair_t             cap_pair;
  pair_t [DEPTH-1:0] hist;
  logic  [DEPTH-1:0] hist_vld;
  pair_t             out_pair;

  assign cap_pair.insn = fetch_data;
  assign cap_pair.addr = pend_addr;

  cpd_align u_align (
    .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .insn_valid(insn_valid),
    .pend_vld(pend_vld), .pend_addr(pend_addr)
  );

  cpd_history #(.DEPTH(DEPTH)) u_hist (
    .clk(clk), .rst_n(rst_n), .push(pend_vld), .hold(hold), .new_pair(cap_pair),
    .slots(hist), .slot_vld(hist_vld)
  );

  cpd_issue #(.DEPTH(DEPTH)) u_issue (
    .clk(clk), .rst_n(rst_n), .disp_newest(disp_newest), .disp_older(disp_older),
    .slots(hist), .slot_vld(hist_vld), .issue_vld(issue_vld), .issue_pair(out_pair)
  );

  assign issue_insn = out_pair.insn;
  assign issue_addr = out_pair.addr;

  // R6: the issue pulse is a single cycle unless a strobe was held high
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && !$past(disp_newest || disp_older, 2)) |=> !issue_vld || $past(disp_newest || disp_older));
endmodule

// File: tb/cpd_top_tb_top.sv
module cpd_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_addr = '0, fetch_data = '0;
  logic        insn_valid = 1'b0, disp_newest = 1'b0, disp_older = 1'b0, hold = 1'b0;
  logic        issue_vld;
  logic [31:0] issue_insn, issue_addr;

  always #2.5 clk = ~clk;  // 200 MHz

  cpd_top dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .fetch_data(fetch_data),
    .insn_valid(insn_valid), .disp_newest(disp_newest), .disp_older(disp_older),
    .hold(hold), .issue_vld(issue_vld), .issue_insn(issue_insn), .issue_addr(issue_addr)
  );

  typedef struct {
    int          cyc;
    logic        v;
    logic [31:0] insn;
    logic [31:0] addr;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          checks = 0, errors = 0, cyc = 0;
  bit          done = 0;
  string       cur_tag = "R8";
  // expected history: index 0 newest
  logic [31:0] e_insn[2], e_addr[2];
  logic        e_v[2];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] a_of(int seed, int k);
    return 32'h0040_0000 + seed * 32'h100 + k * 4;
  endfunction
  function automatic logic [31:0] d_of(int seed, int k);
    return {seed[7:0], 8'hA5, k[7:0], 8'h3C} ^ 32'h8100_0000;
  endfunction

  task automatic clear_model();
    for (int i = 0; i < 2; i++) begin e_v[i] = 0; e_insn[i] = '0; e_addr[i] = '0; end
    sb_q.delete();
  endtask

  // one bus cycle; pv says this cycle's data completes a fetch whose address was pa
  task automatic step(input logic [31:0] a, input logic iv, input logic [31:0] d,
                      input logic pv, input logic [31:0] pa,
                      input logic dn, input logic dol, input logic hd);
    exp_t e;
    @(negedge clk); #1;
    fetch_addr = a; insn_valid = iv; fetch_data = d;
    disp_newest = dn; disp_older = dol; hold = hd;
    if (dn || dol) begin
      e.cyc = cyc + 1; e.tag = cur_tag;
      if (dn) begin e.v = e_v[0]; e.insn = e_insn[0]; e.addr = e_addr[0]; end
      else    begin e.v = e_v[1]; e.insn = e_insn[1]; e.addr = e_addr[1]; end
      sb_q.push_back(e);
    end
    if (pv && !hd) begin
      e_v[1] = e_v[0]; e_insn[1] = e_insn[0]; e_addr[1] = e_addr[0];
      e_v[0] = 1'b1;   e_insn[0] = d;         e_addr[0] = pa;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++)
      step(32'hBAD0_0000 + i, 0, 32'hFFFF_0000 + i, 0, '0, 0, 0, 0);
  endtask

  task automatic disp(input logic dn, input logic dol);
    step(32'hBAD1_0000, 0, 32'hEEEE_0000, 0, '0, dn, dol, 0);
  endtask

  // n back-to-back fetches; hold high on the cycle that completes pair hold_k;
  // disp_k: cycle index in which a newest-strobe is raised (-1 none)
  task automatic fetch_burst(input int n, input int seed, input int hold_k, input int disp_k);
    for (int k = 0; k < n + 2; k++) begin
      logic [31:0] a, d, pa;
      logic pv;
      a  = (k < n) ? a_of(seed, k) : 32'hBAD2_0000 + k;
      pv = (k >= 2);
      d  = pv ? d_of(seed, k - 2) : 32'hDDDD_0000 + k;
      pa = pv ? a_of(seed, k - 2) : '0;
      step(a, (k >= 1 && k <= n), d, pv, pa, (k == disp_k), 0, (k - 2 == hold_k));
    end
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst_n = 0; insn_valid = 0; disp_newest = 0; disp_older = 0; hold = 0;
    clear_model();
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (sb_q.size() > 0 && sb_q[0].cyc == cyc) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (issue_vld !== e.v || (e.v && (issue_insn !== e.insn || issue_addr !== e.addr))) begin
          errors++;
          $display("FAIL %s: vld=%0b exp %0b insn=%h exp %h addr=%h exp %h",
                   e.tag, issue_vld, e.v, issue_insn, e.insn, issue_addr, e.addr);
        end
      end else if (issue_vld !== 1'b0) begin
        checks++; errors++;
        $display("FAIL R6: unexpected issue_vld=%0b exp 0 (insn=%h)", issue_vld, issue_insn);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_model();
    do_reset();
    // R8: reset state
    @(negedge clk);
    checks++;
    if (issue_vld !== 1'b0) begin errors++; $display("FAIL R8: issue_vld=%0b exp 0 after reset", issue_vld); end
    cur_tag = "R8 empty strobe"; disp(1, 0); disp(0, 1); idle(2);
    // R1/R3: one fetch, junk around it
    cur_tag = "R1 R3 single fetch"; fetch_burst(1, 1, -1, -1); idle(1); disp(1, 0); idle(1);
    cur_tag = "R8 older slot empty"; disp(0, 1); idle(1);
    // R4/R3/R5 with two entries
    fetch_burst(1, 2, -1, -1); idle(2);
    cur_tag = "R4 older strobe"; disp(0, 1); idle(1);
    cur_tag = "R3 newest strobe"; disp(1, 0); idle(1);
    cur_tag = "R5 both strobes"; disp(1, 1); idle(1);
    // R2: four back-to-back fetches of arbitrary words
    cur_tag = "R2 burst"; fetch_burst(4, 3, -1, -1); idle(1);
    disp(1, 0); disp(0, 1); idle(1);
    // R7: second pair of three completes under hold and is dropped
    cur_tag = "R7 hold"; fetch_burst(3, 4, 1, -1); idle(1);
    disp(0, 1); disp(1, 0); idle(1);
    // R6: consecutive strobes and a strobe during capture
    cur_tag = "R6 strobe in burst"; fetch_burst(2, 5, -1, 2); idle(1);
    cur_tag = "R6 back-to-back strobes"; disp(1, 0); disp(1, 0); disp(0, 1); disp(1, 1); idle(2);
    // R7: hold with no capture leaves history intact
    cur_tag = "R7 idle hold";
    step(32'hBAD3_0000, 0, 32'h1234_5678, 0, '0, 0, 0, 1);
    disp(0, 1); idle(1);
    // R8: reset mid-run empties the history
    do_reset();
    cur_tag = "R8 after reset"; disp(1, 0); disp(0, 1); idle(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule